// File: doc/BRIEF.md
# Symmetric-Coefficient FIR Filter Engine

This block computes a linear-phase FIR filter of `TAPS` taps with a single multiply-accumulate unit. Because the impulse response of a linear-phase filter is mirror-symmetric, only the first half of it is held in a coefficient table. Each stored coefficient is fetched once and multiplied with two samples: one taken by a pointer that walks forward from the newest sample, and one taken by a pointer that walks backward from the oldest. For an odd tap count the last stored entry covers the centre tap. Both pointers meet on the centre sample, so that entry holds half of the centre value.

Samples are signed 16-bit words offered on a valid/ready input. The source cannot be held off. `in_ready` is high only while the engine is idle, and a word offered while it is low is discarded and latches a sticky overrun flag. Each accepted word is written twice into a sample store of `2*TAPS` words, one copy in each half, so any `TAPS`-long window is contiguous. The engine then issues one coefficient step every `STEP_CYCLES` clocks. After the last step it presents the upper 16 bits of the 32-bit accumulator with a one-cycle `out_valid` pulse. The output has no ready and cannot be stalled; a consumer must take the word in its valid cycle. The coefficient table is a parameter, with entry j at bits `[16j +: 16]` of `COEFS`.

Top module: `symfir_engine`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0, `overrun` is 0 and `in_ready` is 1.
- R2: A word is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is low from the next cycle up to the cycle in which `out_valid` is high, and is high again in that cycle.
- R3: The result for a taken sample x[n] is bits 31:16 of the sum over k = 0..TAPS-1 of h[k]*x[n-k]. Here h[k] = h[TAPS-1-k] = c[k] for k below TAPS/2, and c is the stored table.
- R4: For an odd tap count, (TAPS+1)/2 entries are used. The last entry multiplies the centre sample twice, so the effective centre tap is twice the stored value.
- R5: For an even tap count, exactly TAPS/2 entries are used, each applied to two mirrored samples.
- R6: `out_valid` rises exactly ((TAPS+1)/2)*STEP_CYCLES cycles after the accepting edge and stays high for exactly one cycle.
- R7: A word offered while `in_ready` is low does not enter the sample history and has no effect on later results. It sets `overrun`, which stays 1 until reset.
- R8: `out_data` changes only in a cycle where `out_valid` is high and holds its value between results.
- R9: The accumulator is 32 bits and wraps modulo 2^32 on overflow; the output is taken from the wrapped value.
- R10: Reset clears the sample history, so samples before the reset count as zero in later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Engine idle; a sample is taken this cycle if offered |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse: result on out_data |
| out_data | output | 16 | Upper 16 bits of the accumulated sum |
| overrun | output | 1 | Sticky: a sample was offered while busy |

## Verification
The bench runs an odd-length and an even-length instance side by side on more than twice `TAPS` samples. This walks the start pointer through its reload. A design that mishandled the reload or the double write would return stale or missing samples once the window straddles the buffer halves. An impulse exposes the stored table in order, and a centre tap applied once instead of twice shows as a half-size middle value. A run of full-scale negative samples into large coefficients forces the accumulator to wrap, which catches a saturating or widened sum. A word offered mid-computation and a reset with a full history check that dropped input and stale memory never leak into a result.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Number of stored coefficients (dual-sample steps) for a given tap count
  function automatic int coef_steps(input int taps);
    return (taps + 1) / 2;
  endfunction

endpackage

// File: rtl/symfir_sample_store.sv
module symfir_sample_store #(
  parameter int TAPS   = 7,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]         step_idx,
  output logic signed [DATA_W-1:0] fwd_sample,
  output logic signed [DATA_W-1:0] bwd_sample
);
  localparam int DEPTH = 2 * TAPS;
  localparam int AW    = $clog2(DEPTH);

  logic signed [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] head_q;
  logic [AW-1:0] head_next;
  logic [AW-1:0] fwd_addr;
  logic [AW-1:0] bwd_addr;

  // Newest sample sits at head and head+TAPS; the window head..head+TAPS-1
  // is always contiguous, so reads never wrap.
  always_comb begin
    if (head_q == '0) head_next = AW'(TAPS - 1);
    else              head_next = head_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      head_q                   <= head_next;
      mem[head_next]           <= wr_data;
      mem[head_next + AW'(TAPS)] <= wr_data;
    end
  end

  assign fwd_addr   = head_q + AW'(step_idx);
  assign bwd_addr   = head_q + AW'(TAPS - 1) - AW'(step_idx);
  assign fwd_sample = mem[fwd_addr];
  assign bwd_sample = mem[bwd_addr];

endmodule

// File: rtl/symfir_sequencer.sv
module symfir_sequencer
  import symfir_pkg::*;
#(
  parameter int NSTEP       = 4,
  parameter int STEP_CYCLES = 12,
  parameter int IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] step_idx,
  output logic             mac_fwd,
  output logic             mac_bwd,
  output logic             last_tick
);
  localparam int TW = $clog2(STEP_CYCLES);

  seq_state_e       state_q;
  logic [TW-1:0]    tick_q;
  logic [IDX_W-1:0] idx_q;
  logic             step_end;

  assign step_end  = (tick_q == TW'(STEP_CYCLES - 1));
  assign busy      = (state_q == SEQ_RUN);
  assign mac_fwd   = busy && (tick_q == TW'(0));
  assign mac_bwd   = busy && (tick_q == TW'(1));
  assign last_tick = busy && step_end && (idx_q == IDX_W'(NSTEP - 1));
  assign step_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      tick_q  <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_RUN;
            tick_q  <= '0;
            idx_q   <= '0;
          end
        end
        default: begin
          if (step_end) begin
            tick_q <= '0;
            if (idx_q == IDX_W'(NSTEP - 1)) begin
              state_q <= SEQ_IDLE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/symfir_mac.sv
module symfir_mac #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] coef,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [ACC_W-1:0]  acc
);
  logic signed [2*DATA_W-1:0] product;

  assign product = coef * sample;

  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (en)    acc <= acc + ACC_W'(product);
  end

endmodule

// File: rtl/symfir_engine.sv
module symfir_engine
  import symfir_pkg::*;
#(
  parameter int TAPS        = 7,
  parameter int DATA_W      = 16,
  parameter int ACC_W       = 32,
  parameter int STEP_CYCLES = 12,
  parameter int MAX_COEF    = 8,
  parameter logic [MAX_COEF*DATA_W-1:0] COEFS =
    128'h0000_0000_0000_0000_2000_2000_1000_0800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              overrun
);
  localparam int NSTEP = coef_steps(TAPS);
  localparam int IDX_W = $clog2(NSTEP + 1);

  logic signed [DATA_W-1:0] coef_tab [NSTEP];
  logic signed [DATA_W-1:0] fwd_sample, bwd_sample, mac_sample;
  logic signed [ACC_W-1:0]  acc;
  logic [IDX_W-1:0]         step_idx;
  logic busy, mac_fwd, mac_bwd, last_tick, accept;
  logic out_valid_q, overrun_q;
  logic [DATA_W-1:0] out_data_q;

  for (genvar g = 0; g < NSTEP; g++) begin : g_coef
    assign coef_tab[g] = COEFS[g*DATA_W +: DATA_W];
  end

  assign in_ready   = !busy;
  assign accept     = in_valid && !busy;
  assign mac_sample = mac_fwd ? fwd_sample : bwd_sample;

  symfir_sample_store #(
    .TAPS(TAPS), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_data(in_data),
    .step_idx(step_idx), .fwd_sample(fwd_sample), .bwd_sample(bwd_sample)
  );

  symfir_sequencer #(
    .NSTEP(NSTEP), .STEP_CYCLES(STEP_CYCLES), .IDX_W(IDX_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy),
    .step_idx(step_idx), .mac_fwd(mac_fwd), .mac_bwd(mac_bwd),
    .last_tick(last_tick)
  );

  symfir_mac #(
    .DATA_W(DATA_W), .ACC_W(ACC_W)
  ) mac_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .en(mac_fwd || mac_bwd),
    .coef(coef_tab[step_idx]), .sample(mac_sample), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      overrun_q   <= 1'b0;
    end else begin
      out_valid_q <= last_tick;
      if (last_tick) out_data_q <= acc[ACC_W-1 -: DATA_W];
      if (in_valid && busy) overrun_q <= 1'b1;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign overrun   = overrun_q;

endmodule

// File: rtl/symfir_checker.sv
module symfir_checker #(
  parameter int TAPS        = 7,
  parameter int DATA_W      = 16,
  parameter int STEP_CYCLES = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              overrun
);
  localparam int LAT = ((TAPS + 1) / 2) * STEP_CYCLES;

  logic        running;
  logic [31:0] since_accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running      <= 1'b0;
      since_accept <= '0;
    end else if (in_valid && in_ready) begin
      running      <= 1'b1;
      since_accept <= '0;
    end else if (out_valid) begin
      running <= 1'b0;
    end else if (running) begin
      since_accept <= since_accept + 1'b1;
    end
  end

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_ready_with_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (running && since_accept == 32'(LAT)));
  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overrun);
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_valid);

endmodule

bind symfir_engine symfir_checker #(
  .TAPS(TAPS), .DATA_W(DATA_W), .STEP_CYCLES(STEP_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
);

// File: tb/symfir_engine_tb_top.sv
module symfir_engine_tb_top;
  localparam int NA = 7;
  localparam int NB = 6;
  localparam int LAT_A = 4 * 12;
  localparam int LAT_B = 3 * 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic rdy_a, val_a, ovr_a, rdy_b, val_b, ovr_b;
  logic [15:0] dat_a, dat_b;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  int coef_a [4] = '{16'sh0800, 16'sh1000, 16'sh2000, 16'sh2000};
  int coef_b [3] = '{16'sh7FFF, 16'sh7000, 16'sh7FFF};
  int hist_a [NA];
  int hist_b [NB];

  always #5 clk = ~clk;

  symfir_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
    .in_data(in_data), .out_valid(val_a), .out_data(dat_a), .overrun(ovr_a)
  );

  symfir_engine #(
    .TAPS(NB), .COEFS(128'h0000_0000_0000_0000_0000_7FFF_7000_7FFF)
  ) dut_even_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
    .in_data(in_data), .out_valid(val_b), .out_data(dat_b), .overrun(ovr_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_a();
    logic [31:0] s = '0;
    for (int k = 0; k < NA; k++) begin
      int m = (k < NA - 1 - k) ? k : NA - 1 - k;
      int h = (k == NA - 1 - k) ? 2 * coef_a[m] : coef_a[m];
      s = s + 32'(h * hist_a[k]);
    end
    return s[31:16];
  endfunction

  function automatic logic [15:0] model_b();
    logic [31:0] s = '0;
    for (int k = 0; k < NB; k++) begin
      int m = (k < NB - 1 - k) ? k : NB - 1 - k;
      s = s + 32'(coef_b[m] * hist_b[k]);
    end
    return s[31:16];
  endfunction

  task automatic clear_hist();
    for (int k = 0; k < NA; k++) hist_a[k] = 0;
    for (int k = 0; k < NB; k++) hist_b[k] = 0;
  endtask

  // Offer one sample to both engines, optionally poke in_valid while busy.
  task automatic push(input logic [15:0] x, input string req, input int poke_at);
    int lat_a = 0;
    int lat_b = 0;
    logic [15:0] got_a = '0, got_b = '0, exp_a, exp_b;
    for (int k = NA - 1; k > 0; k--) hist_a[k] = hist_a[k-1];
    for (int k = NB - 1; k > 0; k--) hist_b[k] = hist_b[k-1];
    hist_a[0] = int'($signed(x));
    hist_b[0] = int'($signed(x));
    exp_a = model_a();
    exp_b = model_b();
    @(negedge clk);
    check(rdy_a && rdy_b, "R2 ready before offer", int'(rdy_a), 1);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    in_valid = 1'b0;
    check(!rdy_a && !rdy_b, "R2 ready low while busy", int'(rdy_a), 0);
    for (int c = 1; c < 200; c++) begin
      @(negedge clk);
      if (c == poke_at) begin
        in_valid = 1'b1;
        in_data  = 16'h5A5A;
      end else begin
        in_valid = 1'b0;
      end
      if (lat_a != 0 && c == lat_a + 1)
        check(!val_a, "R6 pulse width odd", int'(val_a), 0);
      if (lat_b != 0 && c == lat_b + 1)
        check(!val_b, "R6 pulse width even", int'(val_b), 0);
      if (val_a && lat_a == 0) begin
        lat_a = c;
        got_a = dat_a;
        check(rdy_a, "R2 ready with result", int'(rdy_a), 1);
      end
      if (val_b && lat_b == 0) begin
        lat_b = c;
        got_b = dat_b;
      end
      if (lat_a != 0 && lat_b != 0 && c > lat_a + 1 && c > lat_b + 1) break;
    end
    in_valid = 1'b0;
    check(lat_a == LAT_A, "R6 latency odd", lat_a, LAT_A);
    check(lat_b == LAT_B, "R6 latency even", lat_b, LAT_B);
    check(got_a == exp_a, {req, " R4 odd result"}, int'($signed(got_a)), int'($signed(exp_a)));
    check(got_b == exp_b, {req, " R5 even result"}, int'($signed(got_b)), int'($signed(exp_b)));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    clear_hist();
    @(negedge clk);
    check(!val_a && !val_b, "R1 out_valid low", int'(val_a), 0);
    check(dat_a == 0 && dat_b == 0, "R1 out_data zero", int'(dat_a), 0);
    check(!ovr_a && !ovr_b, "R1 overrun clear", int'(ovr_a), 0);
    check(rdy_a && rdy_b, "R1 ready high", int'(rdy_a), 1);
  endtask

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4242));
    clear_hist();
    do_reset();

    // Impulse exposes the full symmetric response in order (R3, R4, R5)
    push(16'h7FFF, "R3 impulse", 0);
    for (int i = 0; i < NA + 1; i++) push(16'h0000, "R3 impulse tail", 0);

    // Full-scale runs: even engine wraps its accumulator (R9)
    for (int i = 0; i < 8; i++) push(16'h8000, "R9 negative run", 0);
    for (int i = 0; i < 8; i++) push(16'h7FFF, "R9 positive run", 0);

    // Random stream, long enough to cycle the start pointer several times
    for (int i = 0; i < 40; i++) push(16'($urandom()), "R3 random", 0);

    // Output holds between results (R8)
    held = dat_a;
    repeat (25) @(negedge clk);
    check(dat_a == held && !val_a, "R8 hold while idle", int'(dat_a), int'(held));

    // Reset with a full history: stale samples must not appear (R10)
    do_reset();
    push(16'h4000, "R10 after reset", 0);
    push(16'h2000, "R10 after reset", 0);

    // Offer while busy: dropped and flagged (R7)
    check(!ovr_a && !ovr_b, "R7 overrun before", int'(ovr_a), 0);
    push(16'h1234, "R7 poke busy", 10);
    check(ovr_a && ovr_b, "R7 overrun set", int'(ovr_a), 1);
    push(16'hF00D, "R7 poke dropped", 0);
    check(ovr_a && ovr_b, "R7 overrun sticky", int'(ovr_a), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule